// File: doc/BRIEF.md
# Hot-Plug Slot Change Interrupt Unit

This block watches the status lines of six expansion slots and interrupts the host whenever one of them changes level. Each slot contributes four active-low lines: two presence-detect lines, a power-fault line and a retention-lever switch. A lever line at 0 means the lever is closed and a board is seated. Every line is first brought into the clock domain by a two-flop synchronizer. A third flop then detects a change, and a rising edge counts as a change just as a falling edge does.

Software reaches the block through a 32-bit synchronous register port with two registers. The status register at offset 08h always returns the live synchronized line levels and never the latched events. Writing ones to it acknowledges pending events. The mask register at offset 0Ch selects which lines may interrupt. The single `irq` output is a level: it stays high while any unmasked line has unacknowledged changes.

Each line keeps its own small pending-event machine with four states: `PEND_NONE`, `PEND_ONE`, `PEND_TWO` and `PEND_FULL`. A *raise* transition (a change with no acknowledge) moves one state up and stops at `PEND_FULL`. A *retire* transition (an acknowledge with no change) moves one state down and stops at `PEND_NONE`. A *hold* transition keeps the state; it applies when both or neither event occurs. A line is pending in every state except `PEND_NONE`.

Top module: `hpi_top`

## Requirements
- R1: Status register (offset 08h) bit 8*g+s shows the synchronized level of line group g for slot s, where s=0 is slot A and s=5 is slot F. The groups are: g=0 lever switch (bits 5:0), g=1 power fault (bits 13:8), g=2 second presence line (bits 21:16) and g=3 first presence line (bits 29:24). A pin change becomes visible two clock edges after it is applied. After reset, status reads 3F3F3F3Fh while all lines are high.
- R2: Status bits 31:30, 23:22, 15:14 and 7:6 always read 0.
- R3: The mask register (offset 0Ch) resets to FFFFFFFFh. Its 24 implemented bits can be written and read back. Its reserved bits always read 1 and ignore writes.
- R4: A rising or falling change on a line whose mask bit is 0 records a pending event. `irq` goes high three clock edges after the pin change.
- R5: A change on a line whose mask bit is 1 is discarded. Clearing the mask bit later does not raise `irq`.
- R6: Writing 1 to a status bit acknowledges one pending event on that line. Writing 0 has no effect. Only such a write can retire an event.
- R7: A line holds up to three unacknowledged changes; further changes saturate. `irq` from that line stays high until as many acknowledges as held events have been written.
- R8: A change detected in the same cycle as an acknowledge of the same line leaves its pending count unchanged.
- R9: `irq` is high exactly when some line with mask bit 0 is pending. Setting the mask bit of a pending line drops `irq` without discarding the event, and clearing the mask bit brings `irq` back.
- R10: Reads from any address other than 08h and 0Ch return 0. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prs1_n | input | 6 | First presence-detect line per slot, bit 0 = slot A |
| prs2_n | input | 6 | Second presence-detect line per slot |
| pfault_n | input | 6 | Power-fault line per slot |
| lever_n | input | 6 | Retention-lever switch per slot, 0 = closed |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr_en | input | 1 | Write strobe, takes effect at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
Suppose a pending machine has the wrong state, for example a count that is one too high or too low, or an event recorded while the line was masked. The only place this shows is `irq`: it stays high after what should be the final acknowledge, or falls one acknowledge early. It is therefore seen on the clock edge after an acknowledge write, or three edges after a pin change. A broken synchronizer or a wrong bit mapping shows at once in the status read two edges after the pin moves. A wrong mask register shows on the next read of offset 0Ch, and also as an `irq` that never rises or never falls.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
    localparam int N_SLOT     = 6;
    localparam int N_GRP      = 4;
    localparam int GRP_STRIDE = 8;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 8;
    localparam int N_LINE     = N_SLOT * N_GRP;

    localparam logic [ADDR_W-1:0] STAT_OFS = 8'h08;
    localparam logic [ADDR_W-1:0] MASK_OFS = 8'h0C;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_ONE  = 2'd1,
        PEND_TWO  = 2'd2,
        PEND_FULL = 2'd3
    } pend_state_e;

    function automatic logic [REG_W-1:0] impl_bits();
        logic [REG_W-1:0] m;
        m = '0;
        for (int g = 0; g < N_GRP; g++)
            for (int s = 0; s < N_SLOT; s++)
                m[g*GRP_STRIDE + s] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] IMPL_MAP = impl_bits();
endpackage

// File: rtl/hpi_sync.sv
module hpi_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_n,
    output logic [W-1:0] lvl,
    output logic [W-1:0] chg
);
    logic [W-1:0] meta_q, lvl_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            lvl_q  <= '1;
            prev_q <= '1;
        end else begin
            meta_q <= raw_n;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl = lvl_q;
    assign chg = lvl_q ^ prev_q;
endmodule

// File: rtl/hpi_pend_cell.sv
module hpi_pend_cell
    import hpi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic retire,
    output logic pending
);
    pend_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PEND_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_NONE: if (raise && !retire) state_d = PEND_ONE;
            PEND_ONE: begin
                if (raise && !retire)      state_d = PEND_TWO;
                else if (retire && !raise) state_d = PEND_NONE;
            end
            PEND_TWO: begin
                if (raise && !retire)      state_d = PEND_FULL;
                else if (retire && !raise) state_d = PEND_ONE;
            end
            PEND_FULL: if (retire && !raise) state_d = PEND_TWO;
            default: state_d = PEND_NONE;
        endcase
    end

    always_comb begin
        pending = (state_q != PEND_NONE);
    end
endmodule

// File: rtl/hpi_top.sv
module hpi_top
    import hpi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SLOT-1:0] prs1_n,
    input  logic [N_SLOT-1:0] prs2_n,
    input  logic [N_SLOT-1:0] pfault_n,
    input  logic [N_SLOT-1:0] lever_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    logic [N_LINE-1:0] raw_n, lvl, chg;
    logic [REG_W-1:0]  stat_vec, pend_q, mask_q;
    logic              stat_wr, mask_wr;

    assign raw_n = {prs1_n, prs2_n, pfault_n, lever_n};

    hpi_sync #(.W(N_LINE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_n (raw_n),
        .lvl   (lvl),
        .chg   (chg)
    );

    assign stat_wr = reg_wr_en && (reg_addr == STAT_OFS);
    assign mask_wr = reg_wr_en && (reg_addr == MASK_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= reg_wdata | ~IMPL_MAP;
    end

    genvar g, s, r;
    generate
        for (r = 0; r < REG_W; r++) begin : g_rsvd
            if (!IMPL_MAP[r]) begin : g_tie
                assign stat_vec[r] = 1'b0;
                assign pend_q[r]   = 1'b0;
            end
        end
        for (g = 0; g < N_GRP; g++) begin : g_grp
            for (s = 0; s < N_SLOT; s++) begin : g_slot
                localparam int LI = g*N_SLOT + s;
                localparam int RB = g*GRP_STRIDE + s;
                assign stat_vec[RB] = lvl[LI];
                hpi_pend_cell u_cell (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .raise   (chg[LI] && !mask_q[RB]),
                    .retire  (stat_wr && reg_wdata[RB]),
                    .pending (pend_q[RB])
                );
            end
        end
    endgenerate

    assign irq = |(pend_q & ~mask_q);

    always_comb begin
        unique case (reg_addr)
            STAT_OFS: reg_rdata = stat_vec;
            MASK_OFS: reg_rdata = mask_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hpi_chk.sv
module hpi_chk
    import hpi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr_en,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              irq,
    input logic [REG_W-1:0]  mask_q,
    input logic [REG_W-1:0]  pend_q
);
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == STAT_OFS) |-> ((reg_rdata & ~IMPL_MAP) == '0));

    // R3
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == MASK_OFS) |=> (mask_q == ($past(reg_wdata) | ~IMPL_MAP)));

    // R5
    masked_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_q & ~$past(pend_q) & $past(mask_q)) == '0));

    // R6
    retire_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_addr == STAT_OFS) |=> (($past(pend_q) & ~pend_q) == '0));

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr_en));
endmodule

bind hpi_top hpi_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .mask_q    (mask_q),
    .pend_q    (pend_q)
);

// File: tb/sim_hpi_top.sv
module sim_hpi_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  prs1_n = '1, prs2_n = '1, pfault_n = '1, lever_n = '1;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    localparam logic [31:0] IDLE_STAT = 32'h3F3F3F3F;
    localparam logic [31:0] MASK_FLOOR = 32'hC0C0C0C0;

    // {group[1:0], slot[2:0], register bit[4:0]}
    localparam logic [9:0] VEC [8] = '{
        {2'd0, 3'd0, 5'd0},  {2'd0, 3'd5, 5'd5},
        {2'd1, 3'd0, 5'd8},  {2'd1, 3'd3, 5'd11},
        {2'd2, 3'd2, 5'd18}, {2'd2, 3'd5, 5'd21},
        {2'd3, 3'd0, 5'd24}, {2'd3, 3'd5, 5'd29}
    };

    hpi_top u0 (
        .clk(clk), .rst_n(rst_n), .prs1_n(prs1_n), .prs2_n(prs2_n),
        .pfault_n(pfault_n), .lever_n(lever_n), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic flip(input int grp, input int slot);
        case (grp)
            0: lever_n[slot]  = ~lever_n[slot];
            1: pfault_n[slot] = ~pfault_n[slot];
            2: prs2_n[slot]   = ~prs2_n[slot];
            default: prs1_n[slot] = ~prs1_n[slot];
        endcase
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        // reset state R3 R1 R9
        rd(8'h0C, d); chk("R3 mask reset", d, 32'hFFFFFFFF);
        rd(8'h08, d); chk("R1 status after reset", d, IDLE_STAT);
        chk("R9 irq after reset", {31'd0, irq}, 32'd0);

        // R3 read/write of implemented bits, reserved stay one
        wr(8'h0C, 32'h12345678);
        rd(8'h0C, d); chk("R3 mask readback", d, 32'hD2F4D6F8);
        wr(8'h0C, 32'h0);
        rd(8'h0C, d); chk("R3 mask reserved ones", d, MASK_FLOOR);

        // R10 unmapped address
        wr(8'h10, 32'hFFFFFFFF);
        rd(8'h0C, d); chk("R10 write ignored", d, MASK_FLOOR);
        rd(8'h10, d); chk("R10 read zero", d, 32'h0);

        // table walk: R1 R2 R4 R6
        for (int i = 0; i < 8; i++) begin
            int grp, slot, rb;
            grp = int'(VEC[i][9:8]); slot = int'(VEC[i][7:5]); rb = int'(VEC[i][4:0]);
            flip(grp, slot);
            tick(3);
            rd(8'h08, d); chk("R1 R2 status falling", d, IDLE_STAT & ~(32'd1 << rb));
            chk("R4 irq on fall", {31'd0, irq}, 32'd1);
            wr(8'h08, 32'd1 << rb);
            chk("R6 irq after ack", {31'd0, irq}, 32'd0);
            flip(grp, slot);
            tick(3);
            rd(8'h08, d); chk("R1 status rising", d, IDLE_STAT);
            chk("R4 irq on rise", {31'd0, irq}, 32'd1);
            wr(8'h08, 32'd1 << rb);
            chk("R6 irq after second ack", {31'd0, irq}, 32'd0);
        end

        // R4 R1 exact latency on fault slot F (bit 13)
        flip(1, 5);
        tick(2);
        rd(8'h08, d); chk("R1 status after two edges", d, IDLE_STAT & ~32'h2000);
        chk("R4 irq not yet", {31'd0, irq}, 32'd0);
        tick(1);
        chk("R4 irq at third edge", {31'd0, irq}, 32'd1);
        // R6 zero write has no effect
        wr(8'h08, 32'h0);
        chk("R6 zero write keeps irq", {31'd0, irq}, 32'd1);
        wr(8'h08, 32'h2000);
        chk("R6 ack clears", {31'd0, irq}, 32'd0);
        flip(1, 5); tick(3); wr(8'h08, 32'h2000);

        // R8 change in same cycle as ack (lever A, bit 0)
        flip(0, 0); tick(3);
        flip(0, 0); tick(2);
        wr(8'h08, 32'h1);
        chk("R8 cancel keeps one pending", {31'd0, irq}, 32'd1);
        wr(8'h08, 32'h1);
        chk("R8 final ack clears", {31'd0, irq}, 32'd0);

        // R7 saturation (fault A, bit 8)
        for (int k = 0; k < 4; k++) begin
            flip(1, 0); tick(3);
        end
        wr(8'h08, 32'h100);
        wr(8'h08, 32'h100);
        chk("R7 two acks not enough", {31'd0, irq}, 32'd1);
        wr(8'h08, 32'h100);
        chk("R7 three acks clear saturated", {31'd0, irq}, 32'd0);

        // R5 masked changes discarded (second presence A, bit 16)
        wr(8'h0C, 32'h10000);
        flip(2, 0); tick(3);
        flip(2, 0); tick(3);
        chk("R5 masked no irq", {31'd0, irq}, 32'd0);
        wr(8'h0C, 32'h0);
        chk("R5 unmask no irq", {31'd0, irq}, 32'd0);

        // R9 masking a pending line (first presence A, bit 24)
        flip(3, 0); tick(3);
        chk("R9 pending irq", {31'd0, irq}, 32'd1);
        wr(8'h0C, 32'h1000000);
        chk("R9 masked drops irq", {31'd0, irq}, 32'd0);
        wr(8'h0C, 32'h0);
        chk("R9 unmask restores irq", {31'd0, irq}, 32'd1);
        wr(8'h08, 32'h1000000);
        chk("R9 ack clears", {31'd0, irq}, 32'd0);

        finish_run();
    end
endmodule